// File: doc/BRIEF.md
# Buffer Window Streamer

The block keeps one codeword in a local byte buffer and sends chosen slices of it out on a byte stream that uses valid/ready handshaking. Each slice is set by one of four window descriptors. A descriptor gives a start position in the buffer, a byte count and an end-of-walk flag. Software writes the descriptors through a plain register write port. A separate fill port loads the buffer. A start pulse makes the block go through the descriptors in ascending index order. It streams each window in turn and stops after the window whose end flag is set. At that point the buffer is considered consumed, and its valid flag drops.

A raw codeword read typically uses all four windows with cumulative offsets: data, spare, data, spare. Only the last of these windows carries the end flag. An error-corrected read uses a single window for data or spare, or two windows for data then spare. Windows that run past the buffer, windows of zero length and a walk with no end flag are each handled in a defined way and reported.

Top module: `bufseg_extract`

## Requirements
- R1: Descriptor n (n = 0..3) is written at register word address 0xF20 + 4*n. Its layout is: start position in bits 15:0, byte count in bits 30:16, end flag in bit 31. Writes to any other address change no descriptor.
- R2: A start pulse taken while idle makes the block serve the descriptors in order 0, 1, 2, 3. For each one it emits exactly its byte count, reading the buffer at ascending addresses from its start position.
- R3: The walk ends after the descriptor with the end flag completes. `done` is high for exactly one cycle, one cycle after the final byte is accepted, and `bufValid` is low in that cycle.
- R4: A descriptor with a byte count of zero emits nothing. Its end flag still ends the walk.
- R5: If start position plus byte count exceeds 1024, the walk aborts before any byte of that descriptor is sent. `errRange` is then set, `done` pulses and `bufValid` stays as it was. A walk that ends exactly at 1024 is legal.
- R6: If descriptor 3 completes without an end flag, the walk ends with `missingLast` set and `done` pulsed, and `bufValid` is kept. `errRange` and `missingLast` hold until the next accepted start clears them.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change.
- R8: `busy` is high from the cycle after an accepted start until the walk ends. While `busy` is high, descriptor writes, fill writes and start pulses are ignored.
- R9: After reset, `busy`, `outValid`, `done`, `bufValid`, `errRange` and `missingLast` are all low. A fill write taken while idle stores the byte and sets `bufValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Descriptor register write strobe |
| regAddr | input | 12 | Register word address |
| regWrData | input | 32 | Register write data |
| fillEn | input | 1 | Buffer fill write strobe |
| fillAddr | input | 10 | Buffer fill byte address |
| fillData | input | 8 | Buffer fill byte |
| start | input | 1 | Begin a descriptor walk |
| outValid | output | 1 | Stream byte valid |
| outReady | input | 1 | Stream sink ready |
| outData | output | 8 | Stream byte |
| done | output | 1 | One-cycle end-of-walk pulse |
| busy | output | 1 | Walk in progress |
| bufValid | output | 1 | Buffer holds unconsumed data |
| errRange | output | 1 | Last walk aborted on an out-of-range window |
| missingLast | output | 1 | Last walk ran out of descriptors with no end flag |

## Verification
The start is taken at a clock edge, and `busy` rises in the next cycle. The first byte of a non-empty window is valid two cycles after that edge. Each later window adds one cycle for loading its descriptor. `done` together with the final state of `errRange`, `missingLast` and `bufValid` appears in the cycle after the last handshake, or in the cycle after the descriptor that ends the walk is examined. The bench drives inputs at the falling edge and samples one nanosecond later. It predicts each handshake from the valid and ready values seen in that sample. It expects `done` in the very next sample when the walk ends on a byte, and otherwise counts exactly one `done` before it compares the flags.

// File: rtl/bufseg_pkg.sv
package bufseg_pkg;

  // Descriptor word layout; bit positions are decoded by the datapath.
  typedef struct packed {
    logic        last;    // bit 31
    logic [14:0] size;    // bits 30:16
    logic [15:0] offset;  // bits 15:0
  } locDesc_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STREAM
  } walkState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadWin;   // latch window of current descriptor
    logic stepWin;   // one byte accepted
    logic emptyBuf;  // walk ended on end flag
  } dpStrobe_t;

endpackage

// File: rtl/bufseg_dpath.sv
module bufseg_dpath
  import bufseg_pkg::*;
#(
  parameter int               DEPTH     = 1024,
  parameter int               NUM_DESC  = 4,
  parameter int               REG_AW    = 12,
  parameter logic [REG_AW-1:0] BASE_ADDR = 12'hF20,
  localparam int              BUF_AW    = $clog2(DEPTH),
  localparam int              IDX_W     = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              fillEn,
  input  logic [BUF_AW-1:0] fillAddr,
  input  logic [7:0]        fillData,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  descIdx,
  output logic              descZero,
  output logic              descLast,
  output logic              descOvf,
  output logic              winLastByte,
  output logic [7:0]        outData,
  output logic              bufValid
);

  localparam int SUM_W = 17;

  logic [NUM_DESC-1:0][31:0] descBank;
  logic [NUM_DESC-1:0]       descHit;
  logic [7:0]                bufMem [DEPTH];
  logic [BUF_AW-1:0]         winAddr;
  logic [14:0]               winRemain;
  locDesc_t                  curDesc;
  logic [SUM_W-1:0]          endPos;
  logic                      fillOk;

  // Address decode of the descriptor bank.
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_hit
    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(BASE_ADDR + 4 * g);
    assign descHit[g] = regWrEn && !busy && (regAddr == MY_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descBank <= '0;
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (descHit[i]) descBank[i] <= regWrData;
      end
    end
  end

  // Current descriptor decode.
  assign curDesc     = locDesc_t'(descBank[descIdx]);
  assign endPos      = SUM_W'(curDesc.offset) + SUM_W'(curDesc.size);
  assign descZero    = (curDesc.size == '0);
  assign descLast    = curDesc.last;
  assign descOvf     = endPos > SUM_W'(DEPTH);
  assign winLastByte = (winRemain == 15'd1);

  // Buffer storage with fill port.
  assign fillOk = fillEn && !busy;

  always_ff @(posedge clk) begin
    if (fillOk) bufMem[fillAddr] <= fillData;
  end

  assign outData = bufMem[winAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
    end else if (strobe.emptyBuf) begin
      bufValid <= 1'b0;
    end else if (fillOk) begin
      bufValid <= 1'b1;
    end
  end

  // Window address / remaining-byte counters.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winAddr   <= '0;
      winRemain <= '0;
    end else if (strobe.loadWin) begin
      winAddr   <= curDesc.offset[BUF_AW-1:0];
      winRemain <= curDesc.size;
    end else if (strobe.stepWin) begin
      winAddr   <= winAddr + 1'b1;
      winRemain <= winRemain - 1'b1;
    end
  end

  // R8: descriptors do not move while a walk runs
  a_r8_desc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(descBank));

  // R9: an idle fill marks the buffer valid
  a_r9_fill_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !busy) |=> bufValid);

endmodule

// File: rtl/bufseg_ctrl.sv
module bufseg_ctrl
  import bufseg_pkg::*;
#(
  parameter  int NUM_DESC = 4,
  localparam int IDX_W    = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             outReady,
  input  logic             descZero,
  input  logic             descLast,
  input  logic             descOvf,
  input  logic             winLastByte,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] descIdx,
  output logic             outValid,
  output logic             busy,
  output logic             done,
  output logic             errRange,
  output logic             missingLast
);

  walkState_t state;
  logic       inLoad;
  logic       inStream;
  logic       descEnd;
  logic       atTail;

  assign inLoad   = (state == ST_LOAD);
  assign inStream = (state == ST_STREAM);
  assign atTail   = (descIdx == IDX_W'(NUM_DESC - 1));
  assign descEnd  = (inLoad && descZero) || (inStream && outReady && winLastByte);

  assign strobe.loadWin  = inLoad && !descZero && !descOvf;
  assign strobe.stepWin  = inStream && outReady;
  assign strobe.emptyBuf = descEnd && descLast;

  assign outValid = inStream;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      descIdx     <= '0;
      done        <= 1'b0;
      errRange    <= 1'b0;
      missingLast <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state       <= ST_LOAD;
            descIdx     <= '0;
            errRange    <= 1'b0;
            missingLast <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (!descZero && descOvf) begin
            errRange <= 1'b1;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (!descZero) begin
            state <= ST_STREAM;
          end
        end
        ST_STREAM: ;
        default: state <= ST_IDLE;
      endcase
      if (descEnd) begin
        if (descLast) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else if (atTail) begin
          missingLast <= 1'b1;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end else begin
          descIdx <= descIdx + 1'b1;
          state   <= ST_LOAD;
        end
      end
    end
  end

  // R7: a stalled byte stays offered
  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: nothing streams while an abort is flagged
  a_r5_no_stream_on_err: assert property (@(posedge clk) disable iff (!rstN)
    errRange |-> !outValid);

  // R6: the two end-of-walk faults never coexist
  a_r6_fault_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    missingLast |-> !errRange);

endmodule

// File: rtl/bufseg_extract.sv
module bufseg_extract
  import bufseg_pkg::*;
#(
  parameter  int               DEPTH     = 1024,
  parameter  int               NUM_DESC  = 4,
  parameter  int               REG_AW    = 12,
  parameter  logic [REG_AW-1:0] BASE_ADDR = 12'hF20,
  localparam int               BUF_AW    = $clog2(DEPTH),
  localparam int               IDX_W     = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              fillEn,
  input  logic [BUF_AW-1:0] fillAddr,
  input  logic [7:0]        fillData,
  input  logic              start,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              done,
  output logic              busy,
  output logic              bufValid,
  output logic              errRange,
  output logic              missingLast
);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] descIdx;
  logic             descZero;
  logic             descLast;
  logic             descOvf;
  logic             winLastByte;

  bufseg_ctrl #(
    .NUM_DESC(NUM_DESC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .outReady   (outReady),
    .descZero   (descZero),
    .descLast   (descLast),
    .descOvf    (descOvf),
    .winLastByte(winLastByte),
    .strobe     (strobe),
    .descIdx    (descIdx),
    .outValid   (outValid),
    .busy       (busy),
    .done       (done),
    .errRange   (errRange),
    .missingLast(missingLast)
  );

  bufseg_dpath #(
    .DEPTH    (DEPTH),
    .NUM_DESC (NUM_DESC),
    .REG_AW   (REG_AW),
    .BASE_ADDR(BASE_ADDR)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .fillEn     (fillEn),
    .fillAddr   (fillAddr),
    .fillData   (fillData),
    .strobe     (strobe),
    .descIdx    (descIdx),
    .descZero   (descZero),
    .descLast   (descLast),
    .descOvf    (descOvf),
    .winLastByte(winLastByte),
    .outData    (outData),
    .bufValid   (bufValid)
  );

  // R7: stalled byte value holds
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

  // R3: a walk closed by the end flag leaves the buffer empty
  a_r3_empty_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errRange && !missingLast) |-> !bufValid);

endmodule

// File: tb/bufseg_extract_tb.sv
`timescale 1ns/1ps
module bufseg_extract_tb;

  localparam int DEPTH = 1024;
  localparam logic [11:0] BASE = 12'hF20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        fillEn = 1'b0;
  logic [9:0]  fillAddr = '0;
  logic [7:0]  fillData = '0;
  logic        start = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outData;
  logic        done;
  logic        busy;
  logic        bufValid;
  logic        errRange;
  logic        missingLast;

  always #2 clk = ~clk;

  bufseg_extract u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .fillEn(fillEn), .fillAddr(fillAddr),
    .fillData(fillData), .start(start), .outValid(outValid),
    .outReady(outReady), .outData(outData), .done(done), .busy(busy),
    .bufValid(bufValid), .errRange(errRange), .missingLast(missingLast)
  );

  // Reference model state
  int          nChk = 0;
  int          nFail = 0;
  logic [7:0]  mdlMem [DEPTH];
  logic [31:0] mdlDesc [4];
  bit          mdlBufValid = 0;
  int          expQ [$];
  bit          expErr, expMiss, expBuf, endsOnByte;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // R1 layout: offset 15:0, size 30:16, last 31
  task automatic wrDesc(input int idx, input int off, input int size, input bit last);
    logic [31:0] w;
    w = {last, 15'(size), 16'(off)};
    mdlDesc[idx] = w;
    wrReg(BASE + 12'(4 * idx), w);
  endtask

  task automatic fillByte(input int a, input logic [7:0] d);
    fillEn = 1'b1; fillAddr = 10'(a); fillData = d;
    mdlMem[a] = d; mdlBufValid = 1;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  function automatic void computeExpect();
    bit hitLast;
    expQ.delete();
    expErr = 0; expMiss = 0; endsOnByte = 0; hitLast = 0;
    for (int i = 0; i < 4; i++) begin
      int off, size;
      bit last;
      off  = int'(mdlDesc[i][15:0]);
      size = int'(mdlDesc[i][30:16]);
      last = mdlDesc[i][31];
      if (size != 0 && off + size > DEPTH) begin
        expErr = 1;
        break;
      end
      for (int b = 0; b < size; b++) expQ.push_back(int'(mdlMem[off + b]));
      if (last) begin
        hitLast = 1; endsOnByte = (size != 0);
        break;
      end
      if (i == 3) begin
        expMiss = 1; endsOnByte = (size != 0);
      end
    end
    expBuf = hitLast ? 1'b0 : mdlBufValid;
  endfunction

  // readyMode 0: random, 1: always ready. inject: busy-time writes (R8).
  task automatic runWalk(input string tag, input int readyMode, input bit inject);
    bit          prevStall, doneDue;
    logic [7:0]  prevData;
    int          doneSeen, cyc;
    computeExpect();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prevStall = 0; doneDue = 0; doneSeen = 0; cyc = 0; prevData = '0;
    forever begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (inject && cyc < 20) outReady = 1'b0;
      else if (readyMode == 1) outReady = 1'b1;
      else outReady = lfsr[0] | lfsr[3];
      if (inject && cyc == 4) begin
        regWrEn = 1'b1; regAddr = BASE; regWrData = 32'h8000_0000;
        fillEn = 1'b1; fillAddr = 10'd5; fillData = ~mdlMem[5];
        start = 1'b1;
      end else begin
        regWrEn = 1'b0; fillEn = 1'b0; start = 1'b0;
      end
      #1;
      if (doneDue) begin
        chk(done === 1'b1, {"R3 done timing ", tag}, 32'(done), 1);
        doneDue = 0;
      end else if (done && endsOnByte) begin
        chk(0, {"R3 early done ", tag}, 1, 0);
      end
      if (done) doneSeen++;
      if (prevStall)
        chk(outValid === 1'b1 && outData === prevData, {"R7 stall hold ", tag},
            {23'd0, outValid, outData}, {24'd1, prevData});
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(0, {"R2 extra byte ", tag}, 32'(outData), 0);
        else begin
          int e;
          e = expQ.pop_front();
          chk(outData === 8'(e), {"R2 byte ", tag}, 32'(outData), 32'(e));
          if (expQ.size() == 0 && endsOnByte) doneDue = 1;
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (done) break;
      cyc++;
      if (cyc > 20000) begin
        chk(0, {"R3 walk never ended ", tag}, 0, 1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    outReady = 1'b0; regWrEn = 1'b0; fillEn = 1'b0; start = 1'b0;
    #1;
    chk(doneSeen == 1, {"R3 done count ", tag}, 32'(doneSeen), 1);
    chk(expQ.size() == 0, {"R2 missing bytes ", tag}, 32'(expQ.size()), 0);
    chk(errRange === expErr, {"R5 errRange ", tag}, 32'(errRange), 32'(expErr));
    chk(missingLast === expMiss, {"R6 missingLast ", tag}, 32'(missingLast), 32'(expMiss));
    chk(bufValid === expBuf, {"R3 bufValid ", tag}, 32'(bufValid), 32'(expBuf));
    chk(busy === 1'b0, {"R8 busy after walk ", tag}, 32'(busy), 0);
    mdlBufValid = expBuf;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mdlDesc[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk({busy, outValid, done, bufValid, errRange, missingLast} === 6'b0,
        "R9 reset state", {26'd0, busy, outValid, done, bufValid, errRange, missingLast}, 0);

    for (int i = 0; i < DEPTH; i++) fillByte(i, 8'((i * 7 + 3) ^ (i >> 3)));
    #1 chk(bufValid === 1'b1, "R9 fill sets bufValid", 32'(bufValid), 1);
    @(negedge clk);

    // R2 raw codeword: four cumulative windows, end flag on the fourth
    wrDesc(0, 0, 200, 0); wrDesc(1, 200, 12, 0);
    wrDesc(2, 212, 300, 0); wrDesc(3, 512, 20, 1);
    runWalk("raw4", 0, 0);

    // corrected read, data then spare
    fillByte(0, mdlMem[0]);
    wrDesc(0, 0, 512, 0); wrDesc(1, 512, 16, 1);
    runWalk("data+spare", 1, 0);

    fillByte(1, 8'h5A);
    wrDesc(0, 0, 512, 1);
    runWalk("data only", 0, 0);

    fillByte(2, 8'hC3);
    wrDesc(0, 512, 16, 1);
    runWalk("spare only", 1, 0);

    // R4 zero-length windows skipped, end flag honoured
    fillByte(3, 8'h11);
    wrDesc(0, 40, 0, 0); wrDesc(1, 10, 5, 0); wrDesc(2, 0, 0, 1);
    runWalk("R4 zero mid", 0, 0);
    fillByte(4, 8'h22);
    wrDesc(0, 7, 0, 1);
    runWalk("R4 zero last", 1, 0);

    // R5 range abort after a good window; buffer stays valid
    fillByte(5, 8'h33);
    wrDesc(0, 0, 8, 0); wrDesc(1, 1000, 30, 1);
    runWalk("R5 overflow", 0, 0);
    wrDesc(0, 1000, 24, 1);
    runWalk("R5 exact end", 1, 0);

    // R6 no end flag anywhere
    fillByte(6, 8'h44);
    wrDesc(0, 0, 3, 0); wrDesc(1, 3, 3, 0); wrDesc(2, 6, 3, 0); wrDesc(3, 9, 3, 0);
    runWalk("R6 no last", 0, 0);

    // R1 writes outside the descriptor map are dropped
    wrReg(12'hF30, 32'h8000_0000);
    wrReg(12'hF1C, 32'h8000_0000);
    wrReg(12'hF21, 32'h8000_0000);
    runWalk("R1 unmapped", 1, 0);

    // R8 writes and start while busy are ignored
    fillByte(7, 8'h55);
    wrDesc(0, 0, 64, 1);
    runWalk("R8 inject", 0, 1);
    fillByte(8, 8'h66);
    runWalk("R8 after inject", 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule